// File: doc/BRIEF.md
# Circular Message Pointer Manager

This block keeps track of where voice messages live in a row-addressed storage array that is used as a circular buffer. Rows are addressed with 11 bits. The lowest sixteen rows are held back for fixed sound clips. Every pointer the block produces stays above that region. When recording runs past the highest row, it continues at the first normal row, so a single message can straddle the top of the array.

A controller issues one operation per cycle on `op_valid`/`op_code`. The block holds a small table of message start rows, ordered from oldest to newest. It also holds a record pointer to the first free row and a play pointer to the start of the selected message. Erasure is limited to the oldest message, the newest message, or everything. The block checks each operation against the current buffer structure. An operation that the structure does not allow is refused, leaves all state alone, and raises the command-error output. The block does not store the audio data itself.

Top module: `cmp_pointer_mgr`

## Requirements
- R1: One cycle after synchronous reset, `rec_ptr` and `play_ptr` are 0x010, and `mem_full` and `cmd_err` are 0.
- R2: Each accepted row advance moves `rec_ptr` up by one. From 0x7FF the next value is 0x010. No pointer ever takes a value in 0x000..0x00F.
- R3: Closing a recording that advanced at least one row stores it as the newest message and sets `play_ptr` to its start row. Closing a recording with no rows stores nothing and leaves `play_ptr` unchanged.
- R4: `mem_full` rises on the row advance whose new `rec_ptr` equals the start row of the oldest stored message. If no message is stored, the reference is the start row of the recording in progress. While `mem_full` is 1, row advance and record start are refused.
- R5: Forward moves `play_ptr` to the start of the next newer message. From the newest message it moves to the oldest.
- R6: Erase-oldest removes the oldest message and clears `mem_full`. If `play_ptr` was on that message, it moves to the new oldest message. Otherwise it is unchanged.
- R7: Erase-newest removes the newest message, returns `rec_ptr` to that message's start row, and clears `mem_full`. If `play_ptr` was on that message, it moves to the previous message. Otherwise it is unchanged.
- R8: Global erase, or erasing the only stored message, sets both pointers to 0x010 and clears `mem_full`.
- R9: Rewind sets `play_ptr` to the start of the newest message and leaves `rec_ptr` unchanged.
- R10: Op codes are: 0 idle, 1 record start, 2 row advance, 3 record close, 4 forward, 5 erase-oldest, 6 erase-newest, 7 global erase, 8 rewind. Codes 9..15 are refused. Other refusals are:
  - record start while recording or while full;
  - row advance while not recording or while full;
  - record close while not recording;
  - forward or either single erase while recording or while no message is stored;
  - global erase or rewind while recording.

  A refused operation sets `cmd_err` in the next cycle and changes nothing else. An accepted operation other than 0 clears `cmd_err`. Code 0, or `op_valid` low, changes nothing.
- R11: At most 8 messages are stored. A record start when 8 messages are already stored is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 4 | Operation code, see R10 |
| play_ptr | output | 11 | Start row of the selected message |
| rec_ptr | output | 11 | First free row |
| mem_full | output | 1 | Record pointer has reached the oldest data |
| cmd_err | output | 1 | Last operation was refused |

## Verification
The wraparound past row 0x7FF and the full detection can land on the same row advance. The bench provokes this in two ways. First, it records into an empty array for exactly 2032 rows, so the wrap lands on the start of the recording in progress. Second, it records a message that straddles the top of the array until the pointer meets an oldest message at row 0x074. In both cases it then checks that the pointer lands on the expected row and that the full flag is raised in that same cycle. A behavioural queue model runs alongside and is compared against the outputs on every clock. Erase-newest and erase-oldest are also applied while the play pointer sits on the message being removed, so that a pointer move and a table removal coincide.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int ROW_BITS  = 11;
    localparam int RESERVED  = 16;
    localparam int MSG_SLOTS = 8;

    typedef enum logic [3:0] {
        OP_IDLE      = 4'd0,
        OP_REC_BEGIN = 4'd1,
        OP_REC_ROW   = 4'd2,
        OP_REC_CLOSE = 4'd3,
        OP_FWD       = 4'd4,
        OP_DROP_OLD  = 4'd5,
        OP_DROP_NEW  = 4'd6,
        OP_WIPE      = 4'd7,
        OP_REWIND    = 4'd8
    } op_e;

    typedef struct packed {
        op_e  op;
        logic take;
        logic reject;
    } cmd_t;

    function automatic logic code_known(input logic [3:0] code);
        return code <= 4'd8;
    endfunction

endpackage

// File: rtl/cmp_row_step.sv
module cmp_row_step #(
    parameter int ADDR_W   = cmp_pkg::ROW_BITS,
    parameter int RSV_ROWS = cmp_pkg::RESERVED
) (
    input  logic [ADDR_W-1:0] row_i,
    output logic [ADDR_W-1:0] row_o
);
    localparam logic [ADDR_W-1:0] FIRST_ROW = ADDR_W'(RSV_ROWS);
    localparam logic [ADDR_W-1:0] LAST_ROW  = {ADDR_W{1'b1}};

    always_comb begin
        if (row_i == LAST_ROW) row_o = FIRST_ROW;
        else                   row_o = row_i + 1'b1;
    end
endmodule

// File: rtl/cmp_op_check.sv
module cmp_op_check
    import cmp_pkg::*;
(
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic       recording,
    input  logic       full,
    input  logic       has_msg,
    input  logic       ring_full,
    output cmd_t       cmd_o
);
    logic legal;

    always_comb begin
        legal = 1'b0;
        if (code_known(op_code)) begin
            case (op_e'(op_code))
                OP_IDLE:      legal = 1'b1;
                OP_REC_BEGIN: legal = !recording && !full && !ring_full;
                OP_REC_ROW:   legal = recording && !full;
                OP_REC_CLOSE: legal = recording;
                OP_FWD,
                OP_DROP_OLD,
                OP_DROP_NEW:  legal = !recording && has_msg;
                OP_WIPE,
                OP_REWIND:    legal = !recording;
                default:      legal = 1'b0;
            endcase
        end
        cmd_o.op     = code_known(op_code) ? op_e'(op_code) : OP_IDLE;
        cmd_o.take   = op_valid && legal && (op_code != 4'd0);
        cmd_o.reject = op_valid && !legal;
    end
endmodule

// File: rtl/cmp_msg_ring.sv
module cmp_msg_ring #(
    parameter int ADDR_W = cmp_pkg::ROW_BITS,
    parameter int DEPTH  = cmp_pkg::MSG_SLOTS,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_start,
    input  logic              pop_old,
    input  logic              pop_new,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_start,
    output logic [ADDR_W-1:0] oldest_start,
    output logic [ADDR_W-1:0] newest_start,
    output logic [IDX_W-1:0]  head_idx,
    output logic [IDX_W-1:0]  tail_idx,
    output logic [IDX_W-1:0]  newest_idx,
    output logic [CNT_W-1:0]  count
);
    logic [ADDR_W-1:0] start_q [DEPTH];
    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  cnt_q;

    assign tail_idx   = head_q + IDX_W'(cnt_q);
    assign newest_idx = tail_idx - 1'b1;
    assign head_idx   = head_q;
    assign count      = cnt_q;

    assign rd_start     = start_q[rd_idx];
    assign oldest_start = start_q[head_q];
    assign newest_start = start_q[newest_idx];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                   start_q[i] <= '0;
            else if (push && tail_idx == IDX_W'(i))    start_q[i] <= push_start;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else if (push) begin
            cnt_q  <= cnt_q + 1'b1;
        end else if (pop_old) begin
            head_q <= head_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
        end else if (pop_new) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/cmp_pointer_mgr.sv
module cmp_pointer_mgr
    import cmp_pkg::*;
#(
    parameter int ADDR_W   = cmp_pkg::ROW_BITS,
    parameter int RSV_ROWS = cmp_pkg::RESERVED,
    parameter int DEPTH    = cmp_pkg::MSG_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    output logic [ADDR_W-1:0] play_ptr,
    output logic [ADDR_W-1:0] rec_ptr,
    output logic              mem_full,
    output logic              cmd_err
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] FIRST_ROW = ADDR_W'(RSV_ROWS);

    logic [ADDR_W-1:0] rec_q, play_q, cur_q;
    logic              full_q, err_q, recording_q, wrote_q;
    logic [IDX_W-1:0]  pidx_q;

    logic [ADDR_W-1:0] rec_nxt, rd_start, oldest_start, newest_start, oldest_ref;
    logic [IDX_W-1:0]  head_idx, tail_idx, newest_idx, rd_idx, fwd_idx;
    logic [CNT_W-1:0]  cnt;
    logic              has_msg, ring_full, last_msg;
    cmd_t              cmd;

    assign has_msg    = (cnt != '0);
    assign ring_full  = (cnt == CNT_W'(DEPTH));
    assign last_msg   = (cnt == CNT_W'(1));
    assign oldest_ref = has_msg ? oldest_start : cur_q;
    assign fwd_idx    = (pidx_q == newest_idx) ? head_idx : pidx_q + 1'b1;

    always_comb begin
        case (cmd.op)
            OP_FWD:      rd_idx = fwd_idx;
            OP_DROP_OLD: rd_idx = head_idx + 1'b1;
            OP_DROP_NEW: rd_idx = newest_idx - 1'b1;
            default:     rd_idx = pidx_q;
        endcase
    end

    cmp_row_step #(.ADDR_W(ADDR_W), .RSV_ROWS(RSV_ROWS)) u_step (
        .row_i (rec_q),
        .row_o (rec_nxt)
    );

    cmp_op_check u_check (
        .op_valid  (op_valid),
        .op_code   (op_code),
        .recording (recording_q),
        .full      (full_q),
        .has_msg   (has_msg),
        .ring_full (ring_full),
        .cmd_o     (cmd)
    );

    cmp_msg_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ring (
        .clk          (clk),
        .rst          (rst),
        .push         (cmd.take && cmd.op == OP_REC_CLOSE && wrote_q),
        .push_start   (cur_q),
        .pop_old      (cmd.take && cmd.op == OP_DROP_OLD),
        .pop_new      (cmd.take && cmd.op == OP_DROP_NEW),
        .clear        (cmd.take && cmd.op == OP_WIPE),
        .rd_idx       (rd_idx),
        .rd_start     (rd_start),
        .oldest_start (oldest_start),
        .newest_start (newest_start),
        .head_idx     (head_idx),
        .tail_idx     (tail_idx),
        .newest_idx   (newest_idx),
        .count        (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q       <= FIRST_ROW;
            play_q      <= FIRST_ROW;
            cur_q       <= FIRST_ROW;
            full_q      <= 1'b0;
            err_q       <= 1'b0;
            recording_q <= 1'b0;
            wrote_q     <= 1'b0;
            pidx_q      <= '0;
        end else if (cmd.reject) begin
            err_q <= 1'b1;
        end else if (cmd.take) begin
            err_q <= 1'b0;
            case (cmd.op)
                OP_REC_BEGIN: begin
                    recording_q <= 1'b1;
                    wrote_q     <= 1'b0;
                    cur_q       <= rec_q;
                end
                OP_REC_ROW: begin
                    rec_q   <= rec_nxt;
                    wrote_q <= 1'b1;
                    full_q  <= (rec_nxt == oldest_ref);
                end
                OP_REC_CLOSE: begin
                    recording_q <= 1'b0;
                    if (wrote_q) begin
                        play_q <= cur_q;
                        pidx_q <= tail_idx;
                    end
                end
                OP_FWD: begin
                    pidx_q <= fwd_idx;
                    play_q <= rd_start;
                end
                OP_DROP_OLD: begin
                    full_q <= 1'b0;
                    if (last_msg) begin
                        rec_q  <= FIRST_ROW;
                        play_q <= FIRST_ROW;
                    end else if (pidx_q == head_idx) begin
                        pidx_q <= head_idx + 1'b1;
                        play_q <= rd_start;
                    end
                end
                OP_DROP_NEW: begin
                    full_q <= 1'b0;
                    if (last_msg) begin
                        rec_q  <= FIRST_ROW;
                        play_q <= FIRST_ROW;
                    end else begin
                        rec_q <= newest_start;
                        if (pidx_q == newest_idx) begin
                            pidx_q <= newest_idx - 1'b1;
                            play_q <= rd_start;
                        end
                    end
                end
                OP_WIPE: begin
                    full_q <= 1'b0;
                    rec_q  <= FIRST_ROW;
                    play_q <= FIRST_ROW;
                end
                OP_REWIND: begin
                    if (has_msg) begin
                        play_q <= newest_start;
                        pidx_q <= newest_idx;
                    end else begin
                        rec_q  <= FIRST_ROW;
                        play_q <= FIRST_ROW;
                    end
                end
                default: ;
            endcase
        end
    end

    assign play_ptr = play_q;
    assign rec_ptr  = rec_q;
    assign mem_full = full_q;
    assign cmd_err  = err_q;

endmodule

// File: rtl/cmp_pointer_mgr_chk.sv
module cmp_pointer_mgr_chk
    import cmp_pkg::*;
#(
    parameter int ADDR_W   = cmp_pkg::ROW_BITS,
    parameter int RSV_ROWS = cmp_pkg::RESERVED
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [ADDR_W-1:0] play_ptr,
    input logic [ADDR_W-1:0] rec_ptr,
    input logic              mem_full,
    input logic              cmd_err
);
    localparam logic [ADDR_W-1:0] FIRST_ROW = ADDR_W'(RSV_ROWS);
    localparam logic [ADDR_W-1:0] LAST_ROW  = {ADDR_W{1'b1}};

    AST_PTRS_ABOVE_RSV: assert property (@(posedge clk) disable iff (rst)
        rec_ptr >= FIRST_ROW && play_ptr >= FIRST_ROW); // R2

    AST_WRAP_TO_FIRST: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_REC_ROW && rec_ptr == LAST_ROW && !mem_full
        |=> cmd_err || rec_ptr == FIRST_ROW); // R2

    AST_FULL_FROM_ROW: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_full) |-> $past(op_valid && op_code == OP_REC_ROW)); // R4

    AST_FULL_BLOCKS_ROW: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_REC_ROW && mem_full
        |=> cmd_err && $stable(rec_ptr)); // R4

    AST_WIPE_HOME: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code == OP_WIPE
        |=> cmd_err || (rec_ptr == FIRST_ROW && play_ptr == FIRST_ROW && !mem_full)); // R8

    AST_BAD_CODE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_code > 4'd8
        |=> cmd_err && $stable(rec_ptr) && $stable(play_ptr) && $stable(mem_full)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(rec_ptr) && $stable(play_ptr)
                      && $stable(mem_full) && $stable(cmd_err)); // R10

endmodule

bind cmp_pointer_mgr cmp_pointer_mgr_chk #(.ADDR_W(ADDR_W), .RSV_ROWS(RSV_ROWS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .play_ptr (play_ptr),
    .rec_ptr  (rec_ptr),
    .mem_full (mem_full),
    .cmd_err  (cmd_err)
);

// File: tb/cmp_pointer_mgr_test.sv
module cmp_pointer_mgr_test;
    localparam int CLK_PERIOD = 10;
    localparam int RSV  = 16;
    localparam int LAST = 2047;
    localparam int SLOTS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [10:0] play_ptr, rec_ptr;
    logic        mem_full, cmd_err;

    cmp_pointer_mgr uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .play_ptr(play_ptr), .rec_ptr(rec_ptr), .mem_full(mem_full), .cmd_err(cmd_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int m_rec, m_play, m_full, m_err, m_recing, m_wrote, m_cur, m_pidx;
    int q[$];
    string tag = "R1";
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    function automatic int wrap(int r);
        return (r == LAST) ? RSV : r + 1;
    endfunction

    function automatic void m_home();
        m_rec = RSV; m_play = RSV; m_pidx = 0;
    endfunction

    function automatic void m_step(int c);
        bit ok;
        int nx, oldest;
        ok = 0;
        case (c)
            1: if (!m_recing && !m_full && q.size() < SLOTS) begin
                   ok = 1; m_recing = 1; m_wrote = 0; m_cur = m_rec;
               end
            2: if (m_recing && !m_full) begin
                   ok = 1; nx = wrap(m_rec);
                   oldest = (q.size() > 0) ? q[0] : m_cur;
                   m_rec = nx; m_wrote = 1; m_full = (nx == oldest);
               end
            3: if (m_recing) begin
                   ok = 1; m_recing = 0;
                   if (m_wrote) begin
                       q.push_back(m_cur); m_pidx = q.size() - 1; m_play = m_cur;
                   end
               end
            4: if (!m_recing && q.size() > 0) begin
                   ok = 1; m_pidx = (m_pidx == q.size() - 1) ? 0 : m_pidx + 1;
                   m_play = q[m_pidx];
               end
            5: if (!m_recing && q.size() > 0) begin
                   ok = 1; m_full = 0; void'(q.pop_front());
                   if (q.size() == 0) m_home();
                   else if (m_pidx == 0) m_play = q[0];
                   else m_pidx--;
               end
            6: if (!m_recing && q.size() > 0) begin
                   ok = 1; m_full = 0; m_rec = q[$]; void'(q.pop_back());
                   if (q.size() == 0) m_home();
                   else if (m_pidx == q.size()) begin
                       m_pidx = q.size() - 1; m_play = q[m_pidx];
                   end
               end
            7: if (!m_recing) begin
                   ok = 1; m_full = 0; q.delete(); m_home();
               end
            8: if (!m_recing) begin
                   ok = 1;
                   if (q.size() > 0) begin m_pidx = q.size() - 1; m_play = q[m_pidx]; end
                   else m_home();
               end
            default: ok = 0;
        endcase
        if (c != 0) m_err = ok ? 0 : 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_home(); m_full = 0; m_err = 0; m_recing = 0; m_wrote = 0; m_cur = RSV;
            q.delete();
        end else if (op_valid) begin
            m_step(int'(op_code));
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (int'(rec_ptr) != m_rec || int'(play_ptr) != m_play ||
                int'(mem_full) != m_full || int'(cmd_err) != m_err) begin
                fails++;
                $display("FAIL %s: rec=%0d play=%0d full=%0d err=%0d expected rec=%0d play=%0d full=%0d err=%0d",
                         tag, rec_ptr, play_ptr, mem_full, cmd_err, m_rec, m_play, m_full, m_err);
            end
        end
    end

    task automatic chk(string t, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic op(int c);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 4'(c);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_code  = 4'd0;
        end
    endtask

    task automatic record(int rows);
        op(1);
        repeat (rows) op(2);
        op(3);
        idle(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        tag = "R1";
        chk("R1", "rec_ptr", int'(rec_ptr), 16);
        chk("R1", "play_ptr", int'(play_ptr), 16);
        chk("R1", "flags", int'({mem_full, cmd_err}), 0);

        tag = "R3";
        record(0);
        chk("R3", "play after empty close", int'(play_ptr), 16);
        record(5);
        record(3);
        chk("R3", "play on new message", int'(play_ptr), 21);
        record(2);
        chk("R3", "rec after three", int'(rec_ptr), 26);

        tag = "R5";
        op(4); idle(1);
        chk("R5", "fwd newest to oldest", int'(play_ptr), 16);
        op(4); op(4); idle(1);
        chk("R5", "fwd twice", int'(play_ptr), 24);

        tag = "R9";
        op(4); op(8); idle(1);
        chk("R9", "rewind play", int'(play_ptr), 24);
        chk("R9", "rewind rec", int'(rec_ptr), 26);

        tag = "R10";
        op(9); idle(1);
        chk("R10", "bad code err", int'(cmd_err), 1);
        op(2); op(0); idle(1);
        chk("R10", "idle keeps err", int'(cmd_err), 1);
        op(1); idle(1);
        chk("R10", "legal clears err", int'(cmd_err), 0);
        op(4); idle(1);
        chk("R10", "fwd while recording", int'(cmd_err), 1);
        op(3); idle(1);

        tag = "R7";
        op(6); idle(1);
        chk("R7", "rec back to newest start", int'(rec_ptr), 24);
        chk("R7", "play to previous", int'(play_ptr), 21);

        tag = "R6";
        op(4); op(5); idle(1);
        chk("R6", "play to new oldest", int'(play_ptr), 21);

        tag = "R8";
        op(6); idle(1);
        chk("R8", "last erase rec", int'(rec_ptr), 16);
        chk("R8", "last erase play", int'(play_ptr), 16);
        op(4); idle(1);
        chk("R10", "fwd on empty", int'(cmd_err), 1);

        tag = "R11";
        for (int i = 0; i < 8; i++) record(1);
        op(1); idle(1);
        chk("R11", "ninth start refused", int'(cmd_err), 1);
        tag = "R8";
        op(7); idle(1);
        chk("R8", "wipe rec", int'(rec_ptr), 16);

        tag = "R4";
        op(1);
        repeat (2032) op(2);
        idle(1);
        chk("R2", "wrap lands on first row", int'(rec_ptr), 16);
        chk("R4", "full with wrap", int'(mem_full), 1);
        op(2); idle(1);
        chk("R4", "row refused when full", int'(cmd_err), 1);
        op(3); op(1); idle(1);
        chk("R4", "start refused when full", int'(cmd_err), 1);
        op(5); idle(1);
        chk("R8", "full cleared", int'(mem_full), 0);

        record(100);
        record(100);
        op(5); idle(1);
        chk("R6", "play unchanged", int'(play_ptr), 116);
        op(1);
        repeat (1932) op(2);
        idle(1);
        chk("R4", "meets oldest", int'(rec_ptr), 116);
        chk("R4", "full on straddle", int'(mem_full), 1);
        op(3); idle(1);
        chk("R3", "straddling message play", int'(play_ptr), 216);
        tag = "R5";
        op(4); idle(1);
        chk("R5", "fwd wraps", int'(play_ptr), 116);
        tag = "R7";
        op(6); idle(1);
        chk("R7", "rec after drop newest", int'(rec_ptr), 216);
        chk("R7", "full cleared", int'(mem_full), 0);
        idle(2);
        finish_run();
    end
endmodule